// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block owns the program counter of a 16-bit pipelined processor. The PC is byte-addressed and every instruction is 2 bytes long. On each clock edge where advancing is allowed, the block picks the next PC from three sources:

- the sequential successor;
- a PC-relative branch target, used only when a source register equals a dedicated comparison register;
- an absolute jump target taken from a 12-bit field.

The call form of the jump also produces a return address, which is written into the return-address register. A stall input from the load-use hazard logic freezes the PC for as long as it is held low.

The opcode, the branch offset, the jump field and the two compared register values all arrive from the decode/execute side of the pipeline. The PC and the link outputs are registered. The link pair is valid in the cycle after the call is accepted.

Top module: `npc_unit`

## Requirements
- R1: When `advance` is 1 and the opcode is not 4'hD, 4'hE or 4'hF, the next PC is PC + 2, wrapping modulo 2^16.
- R2: When `advance` is 1 and the opcode is 4'hD (compare-branch), the next PC depends on the comparison. If `rs_val` equals `brn_val`, it is PC + 2 + `imm`, with `imm` taken as a signed 8-bit two's-complement byte offset. Otherwise it is PC + 2.
- R3: When `advance` is 1 and the opcode is 4'hE (jump), the next PC is `jtarget` zero-extended to 16 bits.
- R4: When `advance` is 1 and the opcode is 4'hF (jump-and-link), the next PC is the zero-extended `jtarget`. In the following cycle, `link_data` holds the PC of that instruction plus 4.
- R5: When `advance` is 0, the PC keeps its value and `link_we` is 0 in the following cycle, whatever the opcode.
- R6: `link_we` is 1 in a cycle only if the previous edge accepted opcode 4'hF with `advance` high.
- R7: A synchronous active-high `rst` sets the PC to 0 and `link_we` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | PC update enable; low during a stall |
| opcode | input | 4 | Opcode of the instruction resolving control flow |
| imm | input | 8 | Signed branch offset in bytes |
| jtarget | input | 12 | Absolute jump target field |
| rs_val | input | 16 | Source register value for the branch comparison |
| brn_val | input | 16 | Comparison register value |
| pc | output | 16 | Registered program counter |
| link_we | output | 1 | Write strobe for the return-address register |
| link_data | output | 16 | Return address (call PC + 4) |

## Verification
The assertions assume that the opcode and operand inputs are settled at every rising edge. They also assume that `advance` is a plain level, not something that changes between edges. The bench meets these assumptions by driving every input on the falling edge and sampling the outputs one time unit after the rising edge. No assertion constrains the operand values themselves, so the bench feeds both positive and negative branch offsets, equal and unequal comparisons, and stalls that land on jump and call opcodes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_BRB = 4'hD;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'hE;
  localparam logic [OPC_W-1:0] OPC_JAL = 4'hF;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BRN = 2'd1,
    SRC_ABS = 2'd2
  } npc_src_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output npc_src_e         src,
  output logic             is_call
);
  always_comb begin
    src     = SRC_SEQ;
    is_call = 1'b0;
    // jump forms are decoded first so they win over a branch
    if (opcode == OPC_JMP || opcode == OPC_JAL) begin
      src     = SRC_ABS;
      is_call = (opcode == OPC_JAL);
    end else if (opcode == OPC_BRB) begin
      src = SRC_BRN;
    end
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int IMM_W  = 8,
  parameter int JMP_W  = 12,
  parameter int DATA_W = 16,
  parameter int STEP   = 2
) (
  input  logic [PC_W-1:0]   pc_cur,
  input  npc_src_e          src,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JMP_W-1:0]  jtarget,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] brn_val,
  output logic [PC_W-1:0]   pc_next
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] abs_pc;
  logic            match;

  assign seq_pc  = pc_cur + STEP_V;
  assign off_ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign abs_pc  = {{(PC_W-JMP_W){1'b0}}, jtarget};
  assign match   = (rs_val == brn_val);

  always_comb begin
    unique case (src)
      SRC_ABS: pc_next = abs_pc;
      SRC_BRN: pc_next = match ? seq_pc + off_ext : seq_pc;
      default: pc_next = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link #(
  parameter int PC_W     = 16,
  parameter int LINK_OFS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PC_W-1:0] pc_cur,
  output logic            link_we,
  output logic [PC_W-1:0] link_data
);
  localparam logic [PC_W-1:0] OFS_V = PC_W'(LINK_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      link_we <= take;
      if (take) link_data <= pc_cur + OFS_V;
    end
  end

  AST_LINK_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !link_we) else $error("link strobe after reset"); // R7
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int IMM_W    = 8,
  parameter int JMP_W    = 12,
  parameter int DATA_W   = 16,
  parameter int STEP     = 2,
  parameter int LINK_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JMP_W-1:0]  jtarget,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] brn_val,
  output logic [PC_W-1:0]   pc,
  output logic              link_we,
  output logic [PC_W-1:0]   link_data
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);
  localparam logic [PC_W-1:0] OFS_V  = PC_W'(LINK_OFS);

  npc_src_e        src;
  logic            is_call;
  logic [PC_W-1:0] pc_next;

  npc_decode u_dec (
    .opcode  (opcode),
    .src     (src),
    .is_call (is_call)
  );

  npc_target #(
    .PC_W   (PC_W),
    .IMM_W  (IMM_W),
    .JMP_W  (JMP_W),
    .DATA_W (DATA_W),
    .STEP   (STEP)
  ) u_tgt (
    .pc_cur  (pc),
    .src     (src),
    .imm     (imm),
    .jtarget (jtarget),
    .rs_val  (rs_val),
    .brn_val (brn_val),
    .pc_next (pc_next)
  );

  npc_link #(
    .PC_W     (PC_W),
    .LINK_OFS (LINK_OFS)
  ) u_lnk (
    .clk       (clk),
    .rst       (rst),
    .take      (advance && is_call),
    .pc_cur    (pc),
    .link_we   (link_we),
    .link_data (link_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (advance) pc <= pc_next;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> pc == '0) else $error("pc not cleared"); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc) && !link_we) else $error("stall moved pc"); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    advance && opcode != OPC_BRB && opcode != OPC_JMP && opcode != OPC_JAL
    |=> pc == $past(pc) + STEP_V) else $error("bad sequential step"); // R1
  AST_BRANCH_MISS: assert property (@(posedge clk) disable iff (rst)
    advance && opcode == OPC_BRB && rs_val != brn_val
    |=> pc == $past(pc) + STEP_V) else $error("untaken branch moved"); // R2
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    advance && (opcode == OPC_JMP || opcode == OPC_JAL)
    |=> pc == PC_W'($past(jtarget))) else $error("jump target wrong"); // R3
  AST_LINK_SRC: assert property (@(posedge clk) disable iff (rst)
    link_we |-> $past(advance) && $past(opcode) == OPC_JAL) else $error("stray link"); // R6
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_data == $past(pc) + OFS_V) else $error("link value wrong"); // R4
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [7:0]  imm = 8'h00;
  logic [11:0] jtarget = 12'h000;
  logic [15:0] rs_val = 16'h0000;
  logic [15:0] brn_val = 16'h0000;
  logic [15:0] pc;
  logic        link_we;
  logic [15:0] link_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_pc = 16'h0000;

  always #4 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rst(rst), .advance(advance), .opcode(opcode), .imm(imm),
    .jtarget(jtarget), .rs_val(rs_val), .brn_val(brn_val),
    .pc(pc), .link_we(link_we), .link_data(link_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic adv, input logic [3:0] op, input logic [7:0] im,
                      input logic [11:0] jt, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    advance = adv; opcode = op; imm = im; jtarget = jt; rs_val = a; brn_val = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    exp_pc = 16'h0000;
    chk("R7 pc", pc, exp_pc);
    chk("R7 link_we", {15'd0, link_we}, 16'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 4'h1, 8'h7F, 12'hFFF, 16'd1, 16'd1);
      exp_pc = exp_pc + 16'd2;
      chk("R1 seq", pc, exp_pc);
    end
    step(1'b1, 4'hA, 8'h00, 12'h000, 16'd0, 16'd0);
    exp_pc = exp_pc + 16'd2;
    chk("R1 seq li", pc, exp_pc);
  endtask

  task automatic t_branch();
    step(1'b1, 4'hD, 8'h10, 12'h000, 16'h1234, 16'h1234);
    exp_pc = exp_pc + 16'd2 + 16'd16;
    chk("R2 taken fwd", pc, exp_pc);
    step(1'b1, 4'hD, 8'hF0, 12'h000, 16'h0005, 16'h0005);
    exp_pc = exp_pc + 16'd2 - 16'd16;
    chk("R2 taken back", pc, exp_pc);
    step(1'b1, 4'hD, 8'h40, 12'h000, 16'h0005, 16'h0006);
    exp_pc = exp_pc + 16'd2;
    chk("R2 not taken", pc, exp_pc);
  endtask

  task automatic t_jump();
    step(1'b1, 4'hE, 8'hFF, 12'hABC, 16'd3, 16'd3);
    exp_pc = 16'h0ABC;
    chk("R3 jump", pc, exp_pc);
    chk("R6 no link on jump", {15'd0, link_we}, 16'd0);
  endtask

  task automatic t_call();
    logic [15:0] ret;
    ret = exp_pc + 16'd4;
    step(1'b1, 4'hF, 8'h00, 12'h123, 16'd0, 16'd1);
    exp_pc = 16'h0123;
    chk("R4 call pc", pc, exp_pc);
    chk("R4 link data", link_data, ret);
    chk("R6 link strobe", {15'd0, link_we}, 16'd1);
    step(1'b1, 4'h2, 8'h00, 12'h000, 16'd0, 16'd0);
    exp_pc = exp_pc + 16'd2;
    chk("R6 strobe drops", {15'd0, link_we}, 16'd0);
  endtask

  task automatic t_stall();
    step(1'b0, 4'hF, 8'h00, 12'h777, 16'd0, 16'd0);
    chk("R5 hold on call", pc, exp_pc);
    chk("R5 no link", {15'd0, link_we}, 16'd0);
    step(1'b0, 4'hD, 8'h20, 12'h000, 16'd9, 16'd9);
    chk("R5 hold on branch", pc, exp_pc);
    step(1'b1, 4'h1, 8'h00, 12'h000, 16'd0, 16'd0);
    exp_pc = exp_pc + 16'd2;
    chk("R5 resume", pc, exp_pc);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_sequential();
    t_branch();
    t_jump();
    t_call();
    t_stall();
    step(1'b1, 4'hE, 8'h00, 12'h456, 16'd0, 16'd0);
    t_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule